// File: doc/BRIEF.md
# Serial Sampling Converter Readout Controller

This block runs an 18-bit successive-approximation converter with a serial output from the host side. After a startup hold-off that follows reset, it raises the conversion-start line at a programmable interval. It then watches the converter's busy line. Once busy has been seen high and then low again, the block enables the converter's data output and clocks out one word on a serial clock. That clock toggles once per system cycle, so it runs at half the system rate.

The converter changes its data line on serial-clock rising edges. The controller therefore takes the most significant bit while the clock is still low, before the first rising edge, and takes every later bit on a falling edge. The finished word appears on `data_o` together with a one-cycle `valid_o` pulse. If busy never completes within a fixed window, the controller flags a timeout and skips the read. Between reads the serial clock and the output enable stay low so that the converter and the line draw no power.

Top module: `sar_readout_ctrl`

## Requirements
- R1: No conversion start occurs within STARTUP_CYCLES clock cycles of reset release (default 2000, which is 20 us at 100 MHz). If the period has already elapsed, the first `cnv_o` rise appears exactly STARTUP_CYCLES+1 cycles after release.
- R2: When a full frame fits inside the period, consecutive `cnv_o` rises are exactly `period_i` cycles apart.
- R3: `cnv_o` never rises while busy is high. With a period shorter than a frame, the next start waits until the previous frame has finished.
- R4: Each start is a `cnv_o` pulse exactly CNV_CYCLES cycles wide (default 2). `cnv_o` then stays low until the next start.
- R5: `sdo_en_o` rises only after busy has been high and has fallen again. It stays high only for the duration of the read.
- R6: Each read makes exactly DATA_W (18) serial clock pulses. `sck_o` is low whenever `sdo_en_o` is low.
- R7: The word is assembled most significant bit first. Bit 17 is sampled before the first `sck_o` rising edge, and bits 16 down to 0 are sampled on the following falling edges. `data_o` equals the converter's word.
- R8: `valid_o` is high for exactly one cycle per completed read. `data_o` holds its value until the next completed read.
- R9: If busy has not fallen within TIMEOUT_CYCLES cycles (default 200) of a start, `timeout_o` pulses for one cycle exactly TIMEOUT_CYCLES cycles after the `cnv_o` rise. No read and no `valid_o` follow that start.
- R10: During reset, `cnv_o`, `sck_o`, `sdo_en_o`, `valid_o`, `timeout_o` and `data_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | PERIOD_W | Start interval in system cycles |
| cnv_o | output | 1 | Conversion start pulse |
| busy_i | input | 1 | Converter busy, asynchronous to clk_i |
| sck_o | output | 1 | Serial clock to the converter |
| sdo_i | input | 1 | Serial data from the converter |
| sdo_en_o | output | 1 | Converter data output enable, active high |
| data_o | output | DATA_W | Last captured word |
| valid_o | output | 1 | One-cycle pulse marking a new word |
| timeout_o | output | 1 | One-cycle pulse when busy fails to complete |

## Verification
Two situations are hard to reach from the ports: the timeout path, and a start held back by a busy line that is still high after a timeout. Each needs the converter model to keep busy up for longer than the timeout window. The bench therefore marks selected frames so that the model holds busy well past that window. The period is also switched between a long value, where start intervals are exact, and a very short one, where every start must wait for idle. Random conversion lengths, from a single cycle up to 150 cycles, move the busy fall relative to the synchronizer. Alternating and all-ones words expose any bit slip.

// File: rtl/sar_readout_pkg.sv
package sar_readout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_READ
  } ctrl_state_e;
endpackage

// File: rtl/sar_pace_timer.sv
module sar_pace_timer #(
  parameter int STARTUP_CYCLES = 2000,
  parameter int PERIOD_W       = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                start_i,
  output logic                ready_o,
  output logic                due_o
);
  localparam int STW = $clog2(STARTUP_CYCLES + 1);

  logic [STW-1:0]      st_cnt_q;
  logic [PERIOD_W-1:0] per_cnt_q;

  assign ready_o = (st_cnt_q == STW'(STARTUP_CYCLES));
  assign due_o   = ({1'b0, per_cnt_q} + {{PERIOD_W{1'b0}}, 1'b1}) >= {1'b0, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_cnt_q <= '0;
    end else if (!ready_o) begin
      st_cnt_q <= st_cnt_q + 1'b1;
    end
  end

  // saturating so a long idle never wraps into a false "not due"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_cnt_q <= '0;
    end else if (start_i) begin
      per_cnt_q <= '0;
    end else if (per_cnt_q != '1) begin
      per_cnt_q <= per_cnt_q + 1'b1;
    end
  end

  p_start_after_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ready_o && due_o);
endmodule

// File: rtl/sar_serial_rx.sv
module sar_serial_rx #(
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              sdo_i,
  output logic              sck_o,
  output logic              last_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CW    = $clog2(EDGES);

  logic [CW-1:0]     edge_cnt_q;
  logic              sck_q;
  logic [DATA_W-1:0] sr_q;
  logic              capture;

  // edge 0: MSB before first rise; odd edges: falling, take next bit
  assign capture = active_i &&
                   ((edge_cnt_q == '0) || (edge_cnt_q[0] && (edge_cnt_q < CW'(EDGES - 2))));
  assign last_o  = active_i && (edge_cnt_q == CW'(EDGES - 1));
  assign sck_o   = sck_q;
  assign word_o  = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt_q <= '0;
      sck_q      <= 1'b0;
    end else if (!active_i) begin
      edge_cnt_q <= '0;
      sck_q      <= 1'b0;
    end else begin
      edge_cnt_q <= edge_cnt_q + 1'b1;
      sck_q      <= ~sck_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (capture) begin
      sr_q <= {sr_q[DATA_W-2:0], sdo_i};
    end
  end

  p_sck_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !sck_o);
  p_last_on_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> sck_o);
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_readout_pkg::*;
#(
  parameter int DATA_W         = 18,
  parameter int PERIOD_W       = 16,
  parameter int STARTUP_CYCLES = 2000,
  parameter int CNV_CYCLES     = 2,
  parameter int TIMEOUT_CYCLES = 200,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                cnv_o,
  input  logic                busy_i,
  output logic                sck_o,
  input  logic                sdo_i,
  output logic                sdo_en_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                valid_o,
  output logic                timeout_o
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  ctrl_state_e       state_q;
  logic [SYNC_STAGES-1:0] busy_sq;
  logic              busy_s;
  logic              seen_q;
  logic [TW-1:0]     tmo_cnt_q;
  logic              ready, due, start;
  logic              rx_last;
  logic [DATA_W-1:0] rx_word;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, timeout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_sq <= '0;
    else         busy_sq <= {busy_sq[SYNC_STAGES-2:0], busy_i};
  end
  assign busy_s = busy_sq[SYNC_STAGES-1];

  assign start = (state_q == ST_IDLE) && ready && due && !busy_s;

  sar_pace_timer #(
    .STARTUP_CYCLES(STARTUP_CYCLES),
    .PERIOD_W      (PERIOD_W)
  ) u_pace (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .start_i (start),
    .ready_o (ready),
    .due_o   (due)
  );

  sar_serial_rx #(
    .DATA_W(DATA_W)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(state_q == ST_READ),
    .sdo_i   (sdo_i),
    .sck_o   (sck_o),
    .last_o  (rx_last),
    .word_o  (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      seen_q    <= 1'b0;
      tmo_cnt_q <= '0;
      data_q    <= '0;
      valid_q   <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      valid_q   <= 1'b0;
      timeout_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_CONV;
            seen_q    <= 1'b0;
            tmo_cnt_q <= '0;
          end
        end
        ST_CONV: begin
          tmo_cnt_q <= tmo_cnt_q + 1'b1;
          if (busy_s) seen_q <= 1'b1;
          if (seen_q && !busy_s) begin
            state_q <= ST_READ;
          end else if (tmo_cnt_q == TW'(TIMEOUT_CYCLES - 1)) begin
            state_q   <= ST_IDLE;
            timeout_q <= 1'b1;
          end
        end
        ST_READ: begin
          if (rx_last) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b1;
            data_q  <= rx_word;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o     = (state_q == ST_CONV) && (tmo_cnt_q < TW'(CNV_CYCLES));
  assign sdo_en_o  = (state_q == ST_READ);
  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign timeout_o = timeout_q;

  p_no_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_o) |-> !$past(busy_s));
  p_read_after_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_en_o) |-> !busy_s && $past(seen_q));
  p_sck_in_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> sdo_en_o);
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_hold_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
  p_tmo_no_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !valid_o && !sdo_en_o);
endmodule

// File: tb/tb_sar_readout_ctrl.sv
module tb_sar_readout_ctrl;
  localparam int DW = 18;
  localparam int STARTUP = 2000;
  localparam int CNVW = 2;
  localparam int TMO = 200;
  localparam int NF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] period = 16'd400;
  logic cnv, busy = 1'b0, sck, sdo = 1'b0, sdo_en, valid, tmo;
  logic [DW-1:0] data;

  always #10 clk = ~clk;

  sar_readout_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .cnv_o(cnv), .busy_i(busy),
    .sck_o(sck), .sdo_i(sdo), .sdo_en_o(sdo_en), .data_o(data), .valid_o(valid),
    .timeout_o(tmo)
  );

  int checks = 0, fails = 0;
  int fi = 0, n_valid = 0, n_tmo = 0, exp_tmo = 0;
  int conv_len[NF];
  bit tmo_f[NF];
  logic [DW-1:0] word[NF];
  logic [DW-1:0] q[$];
  logic [DW-1:0] cur_word = '0, last_word = '0;
  int idx = -1;
  bit chk_int = 1'b1;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // converter model
  initial begin
    forever begin
      @(posedge cnv);
      #3;
      chk(!busy, "R3 start while busy", busy, 0);
      if (fi < NF) begin
        automatic int f = fi;
        fi++;
        @(negedge clk);
        if (tmo_f[f]) begin
          busy = 1'b1;
          exp_tmo++;
          repeat (TMO + 60) @(negedge clk);
          busy = 1'b0;
        end else begin
          busy = 1'b1;
          repeat (conv_len[f]) @(negedge clk);
          cur_word = word[f];
          idx = DW - 1;
          sdo = cur_word[DW-1];
          q.push_back(word[f]);
          busy = 1'b0;
        end
      end
    end
  end

  always @(posedge sck) begin
    #2;
    idx--;
    sdo = (idx >= 0) ? cur_word[idx] : 1'b0;
  end

  // monitors
  bit p_cnv = 0, p_en = 0, p_sck = 0, p_valid = 0, first = 1;
  int t_cnv = 0, cnv_w = 0, sck_n = 0;
  always @(negedge clk) if (rst_n) begin
    if (cnv && !p_cnv) begin
      if (first) begin
        chk(cyc == STARTUP + 1, "R1 first start", cyc, STARTUP + 1);
        first = 0;
      end else if (chk_int) begin
        chk(cyc - t_cnv == int'(period), "R2 interval", cyc - t_cnv, period);
      end
      chk(data == last_word, "R8 data held", data, last_word);
      t_cnv = cyc;
      cnv_w = 0;
    end
    if (cnv) cnv_w++;
    if (!cnv && p_cnv) chk(cnv_w == CNVW, "R4 start width", cnv_w, CNVW);
    if (sdo_en && !p_en) begin
      chk(!busy, "R5 read before busy fall", busy, 0);
      sck_n = 0;
    end
    if (sck && !p_sck) sck_n++;
    if (sck && !sdo_en) chk(0, "R6 sck outside read", sck, 0);
    if (!sdo_en && p_en) chk(sck_n == DW, "R6 pulse count", sck_n, DW);
    if (valid) begin
      n_valid++;
      chk(!p_valid, "R8 valid width", p_valid, 0);
      if (q.size() == 0) chk(0, "R7 unexpected word", data, 0);
      else begin
        automatic logic [DW-1:0] e = q.pop_front();
        chk(data == e, "R7 word", data, e);
        last_word = e;
      end
    end
    if (tmo) begin
      n_tmo++;
      chk(n_tmo <= exp_tmo, "R9 unexpected timeout", n_tmo, exp_tmo);
      chk(cyc - t_cnv == TMO, "R9 timeout delay", cyc - t_cnv, TMO);
    end
    p_cnv = cnv; p_en = sdo_en; p_sck = sck; p_valid = valid;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NF; i++) begin
      conv_len[i] = 10 + int'($urandom % 141);
      word[i] = DW'($urandom);
      tmo_f[i] = 1'b0;
    end
    word[0] = 18'h3FFFF; word[1] = 18'h00000; word[2] = 18'h2AAAA;
    word[3] = 18'h15555; word[4] = 18'h20001;
    conv_len[7] = 1; conv_len[26] = 150;
    tmo_f[6] = 1'b1; tmo_f[25] = 1'b1;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk({cnv, sck, sdo_en, valid, tmo} == 5'b0, "R10 reset outputs", {cnv, sck, sdo_en, valid, tmo}, 0);
    chk(data == '0, "R10 reset data", data, 0);
    rst_n = 1'b1;

    wait (fi == 14);
    @(negedge clk); #1;
    period = 16'd5;
    chk_int = 1'b0;
    wait (fi == 30);
    @(negedge clk); #1;
    period = 16'd300;
    wait (fi == 31);
    @(negedge clk); #1;
    chk_int = 1'b1;

    wait (n_valid + n_tmo == NF);
    repeat (5) @(negedge clk);
    chk(n_valid == NF - 2, "R7 word count", n_valid, NF - 2);
    chk(n_tmo == 2, "R9 timeout count", n_tmo, 2);
    chk(q.size() == 0, "R7 pending words", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule